// File: doc/BRIEF.md
# Real-Mode Interrupt Vector Fetcher

This block turns an 8-bit interrupt number into a far pointer, a code segment plus an instruction pointer, by reading a vector table in byte-addressed memory. Each table entry is 4 bytes wide and there are 256 possible numbers. The entry for number `n` sits at the table base plus `4*n`. The physical address is 20 bits wide and wraps modulo 1 MB.

Software can write and read back two table registers through a small register port. The base register gives the table's physical start. The limit register gives the last valid byte offset. A request whose entry would run past the limit reads no memory and produces a one-cycle fault instead.

A separate request flag asks for the fixed power-up entry point. That request answers with segment 0xF000 and offset 0xFFF0 and makes no table access. Memory is reached through a byte-wide request/valid handshake, one byte per transfer.

Top module: `ivec_fetch`

## Requirements
- R1: After reset, base reads 0x00000 and limit reads 0x003FF. `busy`, `done`, `fault` and `mem_req` are all low.
- R2: The entry address is base + 4*number, taken modulo 2^20. The four bytes are read at entry, entry+1, entry+2 and entry+3, in that order, and each of these addresses also wraps modulo 2^20.
- R3: The offset is byte0 + 256*byte1 and the segment is byte2 + 256*byte3. Both appear on `res_off`/`res_seg` together with a one-cycle `done` pulse. They hold their value until the next result.
- R4: `reg_wr` with `reg_sel`=0 loads the base from all 20 bits of `reg_wdata`. With `reg_sel`=1 it loads the limit from bits 15:0. `reg_rdata` shows the selected register, with the limit zero-extended.
- R5: A request accepted with `req_reset`=1 raises `done` in the next cycle with segment 0xF000 and offset 0xFFF0, and reads no memory.
- R6: If 4*number+3 is greater than the limit, the request reads no memory. `fault` pulses for one cycle in the cycle after acceptance, and `res_seg`/`res_off` keep their previous value.
- R7: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. `busy` stays high from the cycle after acceptance through the cycle of `done` or `fault`, then falls. Requests presented while `busy` is high are ignored.
- R8: `mem_req` stays high with a stable `mem_addr` until `mem_valid` arrives. A byte is taken on each edge where both are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_reset | input | 1 | Request the fixed power-up entry instead of a table lookup |
| req_num | input | 8 | Interrupt number |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse: result valid |
| fault | output | 1 | One-cycle pulse: entry beyond limit |
| res_seg | output | 16 | Resolved code segment |
| res_off | output | 16 | Resolved instruction pointer |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects base, 1 selects limit |
| reg_wdata | input | 20 | Register write data |
| reg_rdata | output | 20 | Selected register value |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 20 | Byte read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |

## Verification
The assertions check, on every cycle, several properties of the control path:
- the read request and its address stay steady until the memory answers;
- `done` and `fault` are single-cycle pulses that never coincide;
- `busy` falls right after either pulse;
- results change only with `done`;
- a power-up request answers with the fixed entry on the next cycle.

Only the bench scenarios can show that the data path is correct. That covers the right bytes assembled in the right order, the address arithmetic, including wrap at the top of the 1 MB space, and the limit test at its exact boundary. The bench scenarios also show that a request arriving during a fetch leaves the result and the read count untouched.

// File: rtl/ivec_pkg.sv
package ivec_pkg;

   // bytes per vector table entry and the matching index shift
   localparam int unsigned ENTRY_BYTES = 4;
   localparam int unsigned ENTRY_SHIFT = 2;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_DONE  = 2'd2,
      ST_FAULT = 2'd3
   } ivec_state_e;

   typedef struct packed {
      logic [15:0] seg;
      logic [15:0] off;
   } far_ptr_t;

endpackage

// File: rtl/ivec_tblreg.sv
module ivec_tblreg #(
   parameter int unsigned ADDR_W    = 20,
   parameter int unsigned LIMIT_W   = 16,
   parameter logic [ADDR_W-1:0]  BASE_RST  = '0,
   parameter logic [LIMIT_W-1:0] LIMIT_RST = LIMIT_W'(16'h03FF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              sel,
   input  logic [ADDR_W-1:0] wdata,
   output logic [ADDR_W-1:0] rdata,
   output logic [ADDR_W-1:0] base_o,
   output logic [LIMIT_W-1:0] limit_o
);

   generate
      if (LIMIT_W > ADDR_W) begin : g_bad_width
         $error("ivec_tblreg: LIMIT_W must not exceed ADDR_W");
      end
   endgenerate

   logic [ADDR_W-1:0]  base_q;
   logic [LIMIT_W-1:0] limit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= BASE_RST;
         limit_q <= LIMIT_RST;
      end else if (wr) begin
         if (sel) limit_q <= wdata[LIMIT_W-1:0];
         else     base_q  <= wdata;
      end
   end

   always_comb begin
      rdata = sel ? ADDR_W'(limit_q) : base_q;
   end

   assign base_o  = base_q;
   assign limit_o = limit_q;

   // R4: a write to the base is visible on the read port one cycle later
   p_base_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !sel) |=> (sel || rdata == $past(wdata)));

endmodule

// File: rtl/ivec_addr.sv
module ivec_addr #(
   parameter int unsigned ADDR_W      = 20,
   parameter int unsigned NUM_W       = 8,
   parameter int unsigned LIMIT_W     = 16,
   parameter bit          LIMIT_CHECK = 1'b1
) (
   input  logic [ADDR_W-1:0]  base_i,
   input  logic [LIMIT_W-1:0] limit_i,
   input  logic [NUM_W-1:0]   num_i,
   output logic [ADDR_W-1:0]  entry_addr_o,
   output logic               out_of_range_o
);
   import ivec_pkg::*;

   localparam int unsigned SPAN_W = NUM_W + ENTRY_SHIFT;
   localparam int unsigned CMP_W  = (SPAN_W > LIMIT_W) ? SPAN_W : LIMIT_W;

   generate
      if (SPAN_W > ADDR_W) begin : g_bad_width
         $error("ivec_addr: table span wider than address space");
      end
   endgenerate

   logic [SPAN_W-1:0] scaled;
   logic [SPAN_W-1:0] span_end;

   always_comb begin
      scaled       = {num_i, {ENTRY_SHIFT{1'b0}}};
      span_end     = {num_i, {ENTRY_SHIFT{1'b1}}};
      entry_addr_o = base_i + ADDR_W'(scaled);
   end

   generate
      if (LIMIT_CHECK) begin : g_limit
         assign out_of_range_o = CMP_W'(span_end) > CMP_W'(limit_i);
      end else begin : g_nolimit
         assign out_of_range_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/ivec_seq.sv
module ivec_seq #(
   parameter int unsigned ADDR_W  = 20,
   parameter logic [15:0] RST_SEG = 16'hF000,
   parameter logic [15:0] RST_OFF = 16'hFFF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_rst,
   input  logic              start_flt,
   input  logic [ADDR_W-1:0] entry_addr,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_valid,
   input  logic [7:0]        mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              fault,
   output logic [15:0]       res_seg,
   output logic [15:0]       res_off
);
   import ivec_pkg::*;

   localparam int unsigned IDX_W = $clog2(ENTRY_BYTES);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRY_BYTES - 1);

   generate
      if (ENTRY_BYTES != 4) begin : g_bad_entry
         $error("ivec_seq: entry assembly expects four bytes");
      end
   endgenerate

   ivec_state_e        st_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [IDX_W-1:0]   idx_q;
   logic [31:0]        ent_q;
   far_ptr_t           res_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         addr_q <= '0;
         idx_q  <= '0;
         ent_q  <= '0;
         res_q  <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  addr_q <= entry_addr;
                  idx_q  <= '0;
                  if (start_rst) begin
                     res_q.seg <= RST_SEG;
                     res_q.off <= RST_OFF;
                     st_q      <= ST_DONE;
                  end else if (start_flt) begin
                     st_q <= ST_FAULT;
                  end else begin
                     st_q <= ST_READ;
                  end
               end
            end
            ST_READ: begin
               if (mem_valid) begin
                  ent_q <= {mem_rdata, ent_q[31:8]};
                  if (idx_q == LAST_IDX) begin
                     res_q.seg <= {mem_rdata, ent_q[31:24]};
                     res_q.off <= ent_q[23:8];
                     st_q      <= ST_DONE;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            ST_DONE:  st_q <= ST_IDLE;
            ST_FAULT: st_q <= ST_IDLE;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req  = (st_q == ST_READ);
      mem_addr = addr_q + ADDR_W'(idx_q);
      busy     = (st_q != ST_IDLE);
      done     = (st_q == ST_DONE);
      fault    = (st_q == ST_FAULT);
      res_seg  = res_q.seg;
      res_off  = res_q.off;
   end

   // R8: an outstanding read keeps its request and address until answered
   p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

   // R3: completion is a single-cycle pulse
   p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3: results move only together with done
   p_res_only_on_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !($stable(res_seg) && $stable(res_off)) |-> done);

   // R6: fault is a single-cycle pulse and never coincides with done
   p_fault_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !fault);
   p_done_fault_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fault));

   // R7: busy releases right after a result or fault
   p_busy_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fault) |=> !busy);

endmodule

// File: rtl/ivec_fetch.sv
module ivec_fetch #(
   parameter int unsigned ADDR_W      = 20,
   parameter int unsigned NUM_W       = 8,
   parameter int unsigned LIMIT_W     = 16,
   parameter bit          LIMIT_CHECK = 1'b1,
   parameter logic [15:0] RST_SEG     = 16'hF000,
   parameter logic [15:0] RST_OFF     = 16'hFFF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_reset,
   input  logic [NUM_W-1:0]  req_num,
   output logic              busy,
   output logic              done,
   output logic              fault,
   output logic [15:0]       res_seg,
   output logic [15:0]       res_off,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_valid,
   input  logic [7:0]        mem_rdata
);

   localparam logic [LIMIT_W-1:0] LIMIT_RST = LIMIT_W'((1 << (NUM_W + 2)) - 1);

   generate
      if (ADDR_W < 16) begin : g_bad_addr
         $error("ivec_fetch: ADDR_W too small");
      end
   endgenerate

   logic [ADDR_W-1:0]  base_w;
   logic [LIMIT_W-1:0] limit_w;
   logic [ADDR_W-1:0]  entry_w;
   logic               oob_w;
   logic               accept;

   assign accept = req_valid && !busy;

   ivec_tblreg #(
      .ADDR_W   (ADDR_W),
      .LIMIT_W  (LIMIT_W),
      .BASE_RST ('0),
      .LIMIT_RST(LIMIT_RST)
   ) u_tblreg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (reg_wr),
      .sel    (reg_sel),
      .wdata  (reg_wdata),
      .rdata  (reg_rdata),
      .base_o (base_w),
      .limit_o(limit_w)
   );

   ivec_addr #(
      .ADDR_W     (ADDR_W),
      .NUM_W      (NUM_W),
      .LIMIT_W    (LIMIT_W),
      .LIMIT_CHECK(LIMIT_CHECK)
   ) u_addr (
      .base_i        (base_w),
      .limit_i       (limit_w),
      .num_i         (req_num),
      .entry_addr_o  (entry_w),
      .out_of_range_o(oob_w)
   );

   ivec_seq #(
      .ADDR_W (ADDR_W),
      .RST_SEG(RST_SEG),
      .RST_OFF(RST_OFF)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .start_rst (req_reset),
      .start_flt (oob_w),
      .entry_addr(entry_w),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .mem_valid (mem_valid),
      .mem_rdata (mem_rdata),
      .busy      (busy),
      .done      (done),
      .fault     (fault),
      .res_seg   (res_seg),
      .res_off   (res_off)
   );

   // R5: a power-up request answers with the fixed entry on the next cycle
   p_reset_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && req_reset) |=>
         (done && res_seg == RST_SEG && res_off == RST_OFF));

   // R6: no memory traffic while a fault is reported
   p_fault_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !mem_req);

   // R7: an accepted request makes the block busy on the next cycle
   p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);

endmodule

// File: tb/ivec_fetch_tb.sv
module ivec_fetch_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_reset = 1'b0;
   logic [7:0]  req_num = '0;
   logic        busy, done, fault;
   logic [15:0] res_seg, res_off;
   logic        reg_wr = 1'b0;
   logic        reg_sel = 1'b0;
   logic [19:0] reg_wdata = '0;
   logic [19:0] reg_rdata;
   logic        mem_req;
   logic [19:0] mem_addr;
   logic        mem_valid = 1'b0;
   logic [7:0]  mem_rdata = '0;

   int errors = 0;
   int checks = 0;
   int lat = 0;
   int cnt = 0;
   int nreads = 0;
   logic [19:0] rlog [8];

   always #10 clk = ~clk;

   ivec_fetch u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_reset(req_reset), .req_num(req_num),
      .busy(busy), .done(done), .fault(fault),
      .res_seg(res_seg), .res_off(res_off),
      .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata)
   );

   function automatic logic [7:0] mbyte(input logic [19:0] a);
      return a[7:0] ^ {a[11:8], a[19:16]} ^ {a[15:12], 4'h0} ^ 8'h5A;
   endfunction

   // memory model with programmable latency
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_valid <= 1'b0;
         cnt       <= 0;
      end else if (mem_valid) begin
         mem_valid <= 1'b0;
         cnt       <= 0;
      end else if (mem_req) begin
         if (cnt >= lat) begin
            mem_valid <= 1'b1;
            mem_rdata <= mbyte(mem_addr);
         end else begin
            cnt <= cnt + 1;
         end
      end
   end

   always @(posedge clk) begin
      if (mem_req && mem_valid) begin
         rlog[nreads % 8] <= mem_addr;
         nreads <= nreads + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic sel, input logic [19:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // issue a request; returns at the negedge after acceptance
   task automatic issue(input logic [7:0] n, input logic rq);
      @(negedge clk);
      req_valid = 1'b1; req_num = n; req_reset = rq;
      @(negedge clk);
      req_valid = 1'b0; req_reset = 1'b0;
      chk(busy == 1'b1, "R7 busy after accept", 32'(busy), 32'd1);
   endtask

   task automatic wait_result();
      int n = 0;
      while (!(done || fault) && n < 200) begin
         if (!busy) chk(1'b0, "R7 busy held", 32'(busy), 32'd1);
         @(negedge clk);
         n++;
      end
   endtask

   // {base, limit, number, expect_fault}
   localparam int NV = 9;
   localparam logic [44:0] VEC [NV] = '{
      {20'h00000, 16'h03FF, 8'h00, 1'b0},
      {20'h00000, 16'h03FF, 8'hFF, 1'b0},
      {20'h12340, 16'h03FF, 8'h21, 1'b0},
      {20'hFFF00, 16'h03FF, 8'h50, 1'b0},
      {20'hFFFFE, 16'h03FF, 8'h00, 1'b0},
      {20'h00000, 16'h03FE, 8'hFF, 1'b1},
      {20'h80000, 16'h0007, 8'h01, 1'b0},
      {20'h80000, 16'h0007, 8'h02, 1'b1},
      {20'hABCD0, 16'hFFFF, 8'h80, 1'b0}
   };

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      logic [19:0] vb, ea;
      logic [15:0] vl, eseg, eoff, pseg, poff;
      logic [7:0]  vn;
      logic        vf;
      int          r0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      reg_sel = 1'b0; #1;
      chk(reg_rdata == 20'h00000, "R1 base reset", 32'(reg_rdata), 32'h0);
      reg_sel = 1'b1; #1;
      chk(reg_rdata == 20'h003FF, "R1 limit reset", 32'(reg_rdata), 32'h3FF);
      chk({busy, done, fault, mem_req} == 4'b0, "R1 idle outputs",
          32'({busy, done, fault, mem_req}), 32'h0);

      for (int i = 0; i < NV; i++) begin
         {vb, vl, vn, vf} = VEC[i];
         lat = i % 3;
         wr_reg(1'b0, vb);
         wr_reg(1'b1, {4'h0, vl});
         reg_sel = 1'b0; #1;
         chk(reg_rdata == vb, "R4 base readback", 32'(reg_rdata), 32'(vb));
         reg_sel = 1'b1; #1;
         chk(reg_rdata == {4'h0, vl}, "R4 limit readback", 32'(reg_rdata), 32'(vl));
         pseg = res_seg; poff = res_off;
         r0 = nreads;
         issue(vn, 1'b0);
         wait_result();
         if (vf) begin
            chk(fault && !done, "R6 fault raised", 32'({fault, done}), 32'h2);
            chk(nreads == r0, "R6 no read on fault", 32'(nreads - r0), 32'd0);
            chk(res_seg == pseg && res_off == poff, "R6 result kept",
                {res_seg, res_off}, {pseg, poff});
            @(negedge clk);
            chk(!fault && !busy, "R6 fault single cycle", 32'({fault, busy}), 32'h0);
         end else begin
            ea   = vb + {10'h0, vn, 2'b00};
            eoff = {mbyte(ea + 20'd1), mbyte(ea)};
            eseg = {mbyte(ea + 20'd3), mbyte(ea + 20'd2)};
            chk(done && !fault, "R3 done raised", 32'({done, fault}), 32'h2);
            chk(res_seg == eseg && res_off == eoff, "R3 entry value",
                {res_seg, res_off}, {eseg, eoff});
            chk(nreads - r0 == 4, "R8 four byte reads", 32'(nreads - r0), 32'd4);
            for (int k = 0; k < 4; k++)
               chk(rlog[(r0 + k) % 8] == ea + 20'(k), "R2 read address order",
                   32'(rlog[(r0 + k) % 8]), 32'(ea + 20'(k)));
            @(negedge clk);
            chk(!done && !busy, "R3 done single cycle", 32'({done, busy}), 32'h0);
            chk(res_seg == eseg && res_off == eoff, "R3 result held",
                {res_seg, res_off}, {eseg, eoff});
         end
      end

      // R5: power-up entry, no table read
      r0 = nreads;
      issue(8'h33, 1'b1);
      chk(done == 1'b1, "R5 done next cycle", 32'(done), 32'd1);
      chk(res_seg == 16'hF000 && res_off == 16'hFFF0, "R5 fixed entry",
          {res_seg, res_off}, 32'hF000FFF0);
      chk(nreads == r0, "R5 no read", 32'(nreads - r0), 32'd0);
      @(negedge clk);

      // R7: requests during a fetch are ignored
      wr_reg(1'b0, 20'h00000);
      wr_reg(1'b1, 20'h003FF);
      lat = 3;
      r0 = nreads;
      issue(8'h10, 1'b0);
      req_valid = 1'b1; req_num = 8'h20;
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      wait_result();
      ea = 20'h00040;
      chk(res_seg == {mbyte(ea + 20'd3), mbyte(ea + 20'd2)} &&
          res_off == {mbyte(ea + 20'd1), mbyte(ea)}, "R7 first request wins",
          {res_seg, res_off},
          {mbyte(ea + 20'd3), mbyte(ea + 20'd2), mbyte(ea + 20'd1), mbyte(ea)});
      chk(nreads - r0 == 4, "R7 no extra reads", 32'(nreads - r0), 32'd4);
      repeat (6) begin
         @(negedge clk);
         chk(!busy && !done && !mem_req, "R7 ignored request left no work",
             32'({busy, done, mem_req}), 32'h0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule